// File: doc/BRIEF.md
# Dual Serial ADC Capture Controller

This block sits on the host side of a dual simultaneous-sampling 12-bit converter that is read over one or two serial data lines. It generates the converter's control pins: master clock enable, a combined convert-start/read strobe, an active-low select, the channel address and two mode pins. It then shifts in the 16-bit frames the converter returns. Each frame starts with two flag bits, a pair flag and an A/B flag. Twelve two's-complement data bits follow, most significant first, and the frame ends with two zero bits.

Every decoded value leaves the block as one tagged sample on a valid/ready port. The tags give the converter side (A or B) and the input pair (0 or 1). The block can use both lines at once (two-port). It can also rebuild the A/B pair from two back-to-back frames on line A alone (single-port). In single-port the next strobe is held back so that no strobe falls where the converter would discard it.

The mode, the address and the period come from configuration inputs. The block latches them at the start of each conversion, so the converter sees stable pins for a whole conversion. The pair selection is either fixed or automatically alternating (four-channel).

Top module: `dual_adc_capture`

## Requirements
- R1: While rst_ni is low and until a run begins: adc_start_o=0, adc_cs_no=1, adc_clk_en_o=0, smp_valid_o=0, smp_ovf_o=0, frame_err_o=0.
- R2: Each conversion begins with adc_start_o high for exactly START_W (default 2) cycles. adc_cs_no is low from that first cycle through the last frame bit. adc_clk_en_o is high throughout a run.
- R3: Strobes are spaced P cycles apart in two-port mode and 2*P in single-port mode. P is cfg_period_i, raised to LAT+16 (default 19) if it is smaller.
- R4: Frame bit k (k=0..15) is sampled LAT+k cycles after the first strobe cycle (LAT default 3). Bit 0 is the pair tag (1 = pair 1). Bit 1 is the channel tag (0 = A, 1 = B). Bits 2..13 are data MSB first and pass unchanged to smp_data_o (0x800 most negative, 0x7FF most positive).
- R5: In two-port mode (cfg_single_i=0), line A yields the A sample at LAT+16 cycles after the strobe and line B yields the B sample one cycle later. Both are delivered when smp_ready_i is high.
- R6: In single-port mode (cfg_single_i=1, adc_m1_o=1), the A frame and then the B frame are read from line A. They appear at LAT+16 and LAT+32 cycles after the strobe. Line B is ignored and causes neither samples nor errors.
- R7: In four-channel mode (cfg_four_ch_i=1) adc_m0_o is 1. Pair tags follow the pair flag of each frame, which alternates between conversions.
- R8: A frame is dropped and frame_err_o pulses for one cycle if its two trailing bits are not both 0. The same applies if its channel flag is not the expected one: B on line B, A on line A, and B for the second frame in single-port.
- R9: A presented sample stays valid until accepted. If new samples arrive while one is unread, they replace it and smp_ovf_o pulses for one cycle.
- R10: adc_addr_o, adc_m0_o and adc_m1_o change only when a conversion starts. Configuration changes made during a conversion take effect at the next one.
- R11: When cfg_run_i falls, the current conversion completes. Then no further strobe is issued, adc_cs_no returns high and adc_clk_en_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the converter master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_run_i | input | 1 | Run conversions continuously |
| cfg_four_ch_i | input | 1 | Alternate pairs automatically |
| cfg_single_i | input | 1 | Read both channels over line A |
| cfg_addr_i | input | 1 | Fixed pair select |
| cfg_period_i | input | PER_W | Conversion period in clocks |
| adc_clk_en_o | output | 1 | Master clock enable |
| adc_start_o | output | 1 | Convert-start / read strobe |
| adc_cs_no | output | 1 | Converter select, active low |
| adc_addr_o | output | 1 | Pair address to converter |
| adc_m0_o | output | 1 | Four-channel mode pin |
| adc_m1_o | output | 1 | Single-port mode pin |
| adc_da_i | input | 1 | Serial data line A |
| adc_db_i | input | 1 | Serial data line B |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample accepted |
| smp_data_o | output | 12 | Two's-complement sample |
| smp_chan_o | output | 1 | Channel tag, 0 = A, 1 = B |
| smp_pair_o | output | 1 | Pair tag |
| smp_ovf_o | output | 1 | Unread sample overwritten (pulse) |
| frame_err_o | output | 1 | Framing error (pulse) |

## Verification
Taking the first strobe cycle as cycle 0, the A sample is due at cycle LAT+16. The B sample is due one cycle later in two-port mode and at LAT+32 in single-port mode. Error and overflow pulses fall in the cycle a dropped or overwriting sample would appear. The bench converter model times each frame bit from the strobe it sees on the pins. The monitor records, for every accepted sample, the distance back to the latest strobe, and the checks compare those distances with the figures above. The strobe spacing, pin values and event counts are sampled on falling edges, at least one cycle after the event that caused them.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  parameter int unsigned DATA_W = 12;
  localparam int unsigned FRAME_W = DATA_W + 4;

  typedef struct packed {
    logic four_ch;
    logic single;
    logic addr;
  } mode_t;

  typedef struct packed {
    logic              pair;
    logic              chan;
    logic [DATA_W-1:0] data;
  } sample_t;
endpackage

// File: rtl/dsa_seq.sv
module dsa_seq
  import dsa_pkg::*;
#(
  parameter int unsigned PER_W   = 8,
  parameter int unsigned LAT     = 3,
  parameter int unsigned START_W = 2,
  parameter int unsigned IDX_W   = $clog2(2 * FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  mode_t            cfg_i,
  input  logic [PER_W-1:0] period_i,
  output logic             active_o,
  output logic             start_o,
  output logic             cs_no,
  output mode_t            mode_o,
  output logic             bit_en_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  localparam int unsigned MIN_P = LAT + FRAME_W;
  localparam int unsigned MAX_P = ((2 ** PER_W) > MIN_P) ? (2 ** PER_W) : MIN_P;
  localparam int unsigned CNT_W = $clog2(2 * MAX_P + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_P);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] STW_C = CNT_W'(START_W);
  localparam logic [CNT_W-1:0] FR1_C = CNT_W'(LAT + FRAME_W);
  localparam logic [CNT_W-1:0] FR2_C = CNT_W'(LAT + 2 * FRAME_W);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q, per_q, per_c, last_c, win_end;
  mode_t            mode_q;

  assign per_c   = (CNT_W'(period_i) < MIN_C) ? MIN_C : CNT_W'(period_i);
  // single-port: one period per frame, skip the strobe the converter drops
  assign last_c  = mode_q.single ? ((per_q << 1) - CNT_W'(1)) : (per_q - CNT_W'(1));
  assign win_end = mode_q.single ? FR2_C : FR1_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      per_q    <= MIN_C;
      mode_q   <= '0;
    end else if (!active_q) begin
      if (run_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        per_q    <= per_c;
        mode_q   <= cfg_i;
      end
    end else if (cnt_q == last_c) begin
      if (run_i) begin
        cnt_q  <= '0;
        per_q  <= per_c;
        mode_q <= cfg_i;
      end else begin
        active_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign active_o  = active_q;
  assign start_o   = active_q && (cnt_q < STW_C);
  assign cs_no     = !(active_q && (cnt_q < win_end));
  assign bit_en_o  = active_q && (cnt_q >= LAT_C) && (cnt_q < win_end);
  assign bit_idx_o = IDX_W'(cnt_q - LAT_C);
  assign mode_o    = mode_q;
endmodule

// File: rtl/dsa_deser.sv
module dsa_deser
  import dsa_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    shift_i,
  input  logic    bit_i,
  input  logic    done_i,
  input  logic    exp_chan_i,
  output logic    valid_o,
  output logic    err_o,
  output sample_t smp_o
);
  logic [FRAME_W-2:0] sr_q;
  logic [FRAME_W-1:0] word;
  logic               good;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (shift_i) sr_q <= word[FRAME_W-2:0];
  end

  assign word       = {sr_q, bit_i};
  assign good       = (word[1:0] == 2'b00) && (word[FRAME_W-2] == exp_chan_i);
  assign smp_o.pair = word[FRAME_W-1];
  assign smp_o.chan = word[FRAME_W-2];
  assign smp_o.data = word[FRAME_W-3:2];
  assign valid_o    = done_i && good;
  assign err_o      = done_i && !good;
endmodule

// File: rtl/dsa_outbuf.sv
module dsa_outbuf
  import dsa_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] in_v_i,
  input  sample_t    in_s_i [2],
  input  logic       ready_i,
  output logic       valid_o,
  output sample_t    smp_o,
  output logic       ovf_o
);
  logic    vld_q, pend_q, ovf_q;
  sample_t out_q, pend_s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      pend_q   <= 1'b0;
      ovf_q    <= 1'b0;
      out_q    <= '0;
      pend_s_q <= '0;
    end else if (|in_v_i) begin
      ovf_q <= (vld_q && !ready_i) || pend_q;
      vld_q <= 1'b1;
      if (in_v_i[0]) begin
        out_q    <= in_s_i[0];
        pend_q   <= in_v_i[1];
        pend_s_q <= in_s_i[1];
      end else begin
        out_q  <= in_s_i[1];
        pend_q <= 1'b0;
      end
    end else begin
      ovf_q <= 1'b0;
      if (vld_q && ready_i) begin
        if (pend_q) begin
          out_q  <= pend_s_q;
          pend_q <= 1'b0;
        end else begin
          vld_q <= 1'b0;
        end
      end
    end
  end

  assign valid_o = vld_q;
  assign smp_o   = out_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture
  import dsa_pkg::*;
#(
  parameter int unsigned PER_W   = 8,
  parameter int unsigned LAT     = 3,
  parameter int unsigned START_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_run_i,
  input  logic              cfg_four_ch_i,
  input  logic              cfg_single_i,
  input  logic              cfg_addr_i,
  input  logic [PER_W-1:0]  cfg_period_i,
  output logic              adc_clk_en_o,
  output logic              adc_start_o,
  output logic              adc_cs_no,
  output logic              adc_addr_o,
  output logic              adc_m0_o,
  output logic              adc_m1_o,
  input  logic              adc_da_i,
  input  logic              adc_db_i,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_chan_o,
  output logic              smp_pair_o,
  output logic              smp_ovf_o,
  output logic              frame_err_o
);
  localparam int unsigned IDX_W = $clog2(2 * FRAME_W);
  localparam logic [IDX_W-1:0] END0 = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] END1 = IDX_W'(2 * FRAME_W - 1);

  mode_t            cfg, mode;
  logic             active, bit_en;
  logic [IDX_W-1:0] bit_idx;
  logic [1:0]       line, shift, done, exp_chan, ok_v, bad_v;
  sample_t          smp [2];
  sample_t          out_s;
  logic             err_q;

  assign cfg = '{four_ch: cfg_four_ch_i, single: cfg_single_i, addr: cfg_addr_i};

  dsa_seq #(
    .PER_W  (PER_W),
    .LAT    (LAT),
    .START_W(START_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (cfg_run_i),
    .cfg_i    (cfg),
    .period_i (cfg_period_i),
    .active_o (active),
    .start_o  (adc_start_o),
    .cs_no    (adc_cs_no),
    .mode_o   (mode),
    .bit_en_o (bit_en),
    .bit_idx_o(bit_idx)
  );

  assign line = {adc_db_i, adc_da_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    if (g == 0) begin : g_a
      assign shift[g]    = bit_en;
      assign exp_chan[g] = mode.single && (bit_idx > END0);
    end else begin : g_b
      assign shift[g]    = bit_en && !mode.single;
      assign exp_chan[g] = 1'b1;
    end
    assign done[g] = shift[g] && ((bit_idx == END0) || (bit_idx == END1));

    dsa_deser u_deser (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .shift_i   (shift[g]),
      .bit_i     (line[g]),
      .done_i    (done[g]),
      .exp_chan_i(exp_chan[g]),
      .valid_o   (ok_v[g]),
      .err_o     (bad_v[g]),
      .smp_o     (smp[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else err_q <= |bad_v;
  end

  dsa_outbuf u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_v_i (ok_v),
    .in_s_i (smp),
    .ready_i(smp_ready_i),
    .valid_o(smp_valid_o),
    .smp_o  (out_s),
    .ovf_o  (smp_ovf_o)
  );

  assign adc_clk_en_o = active;
  assign adc_addr_o   = mode.addr;
  assign adc_m0_o     = mode.four_ch;
  assign adc_m1_o     = mode.single;
  assign smp_data_o   = out_s.data;
  assign smp_chan_o   = out_s.chan;
  assign smp_pair_o   = out_s.pair;
  assign frame_err_o  = err_q;
endmodule

// File: rtl/dual_adc_capture_chk.sv
module dual_adc_capture_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic adc_start_o,
  input logic adc_cs_no,
  input logic adc_clk_en_o,
  input logic adc_addr_o,
  input logic adc_m0_o,
  input logic adc_m1_o,
  input logic smp_valid_o,
  input logic smp_ready_i,
  input logic smp_ovf_o,
  input logic frame_err_o
);
  // R2
  start_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> !adc_cs_no);

  // R2
  clk_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_cs_no |-> adc_clk_en_o);

  // R10
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_no && $past(!adc_cs_no) && !$rose(adc_start_o))
      |-> ($stable(adc_addr_o) && $stable(adc_m0_o) && $stable(adc_m1_o)));

  // R9
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_ready_i) |=> smp_valid_o);

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ovf_o |-> $past(smp_valid_o));

  // R8
  err_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> $past(!adc_cs_no));
endmodule

bind dual_adc_capture dual_adc_capture_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adc_start_o (adc_start_o),
  .adc_cs_no   (adc_cs_no),
  .adc_clk_en_o(adc_clk_en_o),
  .adc_addr_o  (adc_addr_o),
  .adc_m0_o    (adc_m0_o),
  .adc_m1_o    (adc_m1_o),
  .smp_valid_o (smp_valid_o),
  .smp_ready_i (smp_ready_i),
  .smp_ovf_o   (smp_ovf_o),
  .frame_err_o (frame_err_o)
);

// File: tb/test_dual_adc_capture.sv
`timescale 1ns/1ps
module test_dual_adc_capture;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, four = 0, single = 0, addr = 0, ready = 1;
  logic [7:0] period = 8'd30;
  logic da = 0, db = 0;
  logic clk_en, start, cs_n, addr_o, m0, m1, valid, chan, pair, ovf, ferr;
  logic [11:0] data;

  always #10 clk = ~clk;

  dual_adc_capture i_dual_adc_capture (
    .clk_i(clk), .rst_ni(rst_n), .cfg_run_i(run), .cfg_four_ch_i(four),
    .cfg_single_i(single), .cfg_addr_i(addr), .cfg_period_i(period),
    .adc_clk_en_o(clk_en), .adc_start_o(start), .adc_cs_no(cs_n),
    .adc_addr_o(addr_o), .adc_m0_o(m0), .adc_m1_o(m1),
    .adc_da_i(da), .adc_db_i(db), .smp_valid_o(valid), .smp_ready_i(ready),
    .smp_data_o(data), .smp_chan_o(chan), .smp_pair_o(pair),
    .smp_ovf_o(ovf), .frame_err_o(ferr));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_starts = 0, last_rise = 0, gap = 0;
  int ovf_cnt = 0, err_cnt = 0;
  logic [13:0] exp_q[$];
  int lat_q[$];
  bit expect_en = 1, use_fixed = 0, bad_trail = 0, bad_chan = 0;
  logic [11:0] fix_a, fix_b, nxt = 12'h123;
  logic pair_tgl = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // converter model: frames timed from the strobe seen on the pins
  int idx = -1, st_len = 0;
  logic prev_st = 0;
  logic [31:0] line_a, line_b;
  always @(negedge clk) begin
    if (!rst_n) begin
      idx = -1; prev_st = 0; da = 0; db = 0; st_len = 0;
    end else begin
      if (start && !prev_st) begin
        logic p;
        logic [11:0] ca, cb;
        logic [15:0] fa, fb;
        bit oka;
        n_starts++;
        gap = cyc - last_rise;
        last_rise = cyc;
        p = m0 ? pair_tgl : addr_o;
        if (m0) pair_tgl = ~pair_tgl;
        if (use_fixed) begin ca = fix_a; cb = fix_b; end
        else begin ca = nxt; nxt += 12'h2A7; cb = nxt; nxt += 12'h2A7; end
        fa = {p, 1'b0, ca, 2'b00};
        fb = {p, 1'b1, cb, 2'b00};
        oka = !(bad_trail || bad_chan);
        if (bad_trail) fa[0] = 1'b1;
        if (bad_chan) fa[14] = 1'b1;
        bad_trail = 0; bad_chan = 0;
        if (m1) begin line_a = {fa, fb}; line_b = '1; end
        else begin line_a = {fa, 16'h0}; line_b = {fb, 16'h0}; end
        if (expect_en) begin
          if (oka) exp_q.push_back({p, 1'b0, ca});
          exp_q.push_back({p, 1'b1, cb});
        end
        idx = 0;
      end else if (idx >= 0) idx++;
      if (start) st_len++;
      else if (prev_st) begin
        chk(st_len == 2, "R2 strobe width", st_len, 2);
        st_len = 0;
      end
      if (idx >= LAT && idx < LAT + 32) begin
        da = line_a[31 - (idx - LAT)];
        db = line_b[31 - (idx - LAT)];
        if (idx == LAT) chk(cs_n == 1'b0, "R2 select low in frame", cs_n, 0);
      end else begin
        da = 0; db = 0;
      end
      if (idx > LAT + 40) idx = -1;
      prev_st = start;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid && ready) begin
        lat_q.push_back(cyc - last_rise);
        if (exp_q.size() == 0) chk(0, "R4 unexpected sample", {pair, chan, data}, 0);
        else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          chk({pair, chan, data} == e, "R4 sample tag/data", {pair, chan, data}, e);
        end
      end
      if (ovf) ovf_cnt++;
      if (ferr) err_cnt++;
    end
  end

  task automatic wait_starts(input int n);
    int t;
    t = n_starts + n;
    while (n_starts < t) @(negedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0, o0, s0;
    repeat (5) @(negedge clk);
    // R1
    chk({start, cs_n, clk_en, valid, ovf, ferr} == 6'b010000, "R1 reset outputs",
        {start, cs_n, clk_en, valid, ovf, ferr}, 6'b010000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({start, cs_n, clk_en} == 3'b010, "R1 idle before run", {start, cs_n, clk_en}, 3'b010);

    // R5 two-port, fixed pair 0
    run = 1;
    wait_starts(3);
    chk(gap == 30, "R3 two-port spacing", gap, 30);
    chk(lat_q.size() >= 2 && lat_q[0] == LAT + 16, "R5 A latency", lat_q[0], LAT + 16);
    chk(lat_q.size() >= 2 && lat_q[1] == LAT + 17, "R5 B latency", lat_q[1], LAT + 17);
    chk({m0, m1, clk_en} == 3'b001, "R2 pins in two-port", {m0, m1, clk_en}, 3'b001);

    // R4 extreme codes
    use_fixed = 1; fix_a = 12'h800; fix_b = 12'h7FF;
    wait_starts(2);
    use_fixed = 0;
    wait_starts(1);

    // R10 address change mid-conversion
    repeat (4) @(posedge clk);
    addr = 1;
    repeat (4) @(negedge clk);
    chk(addr_o == 1'b0, "R10 address held in conversion", addr_o, 0);
    wait_starts(1);
    @(negedge clk);
    chk(addr_o == 1'b1, "R10 address at next start", addr_o, 1);

    // R7 four-channel
    four = 1;
    wait_starts(4);
    @(negedge clk);
    chk(m0 == 1'b1, "R7 four-channel pin", m0, 1);

    // R8 framing errors
    e0 = err_cnt;
    bad_trail = 1;
    wait_starts(2);
    chk(err_cnt == e0 + 1, "R8 trailer error", err_cnt, e0 + 1);
    bad_chan = 1;
    wait_starts(2);
    chk(err_cnt == e0 + 2, "R8 channel flag error", err_cnt, e0 + 2);

    // R6 single-port, line B garbage
    four = 0; single = 1;
    wait_starts(2);
    lat_q.delete();
    e0 = err_cnt;
    wait_starts(2);
    chk(gap == 60, "R3 single-port spacing", gap, 60);
    chk(lat_q.size() >= 2 && lat_q[0] == LAT + 16, "R6 A latency", lat_q[0], LAT + 16);
    chk(lat_q.size() >= 2 && lat_q[1] == LAT + 32, "R6 B latency", lat_q[1], LAT + 32);
    chk(err_cnt == e0, "R6 line B ignored", err_cnt, e0);
    chk(m1 == 1'b1, "R6 single-port pin", m1, 1);

    // R3 clamp
    period = 8'd5;
    wait_starts(3);
    chk(gap == 38, "R3 clamped single-port", gap, 38);
    single = 0;
    wait_starts(3);
    chk(gap == 19, "R3 clamped two-port", gap, 19);

    // R9 hold and overflow
    period = 8'd30;
    wait_starts(2);
    expect_en = 0;
    wait_starts(1);
    ready = 0;
    expect_en = 1;
    o0 = ovf_cnt;
    wait_starts(1);
    repeat (25) @(negedge clk);
    chk(ovf_cnt == o0 + 1, "R9 overflow pulse", ovf_cnt, o0 + 1);
    chk(valid == 1'b1, "R9 sample held", valid, 1);
    ready = 1;

    // R11 stop
    wait_starts(1);
    run = 0;
    s0 = n_starts;
    repeat (80) @(negedge clk);
    chk(n_starts == s0, "R11 no strobe after stop", n_starts, s0);
    chk({cs_n, clk_en} == 2'b10, "R11 idle pins", {cs_n, clk_en}, 2'b10);
    chk(exp_q.size() == 0, "R5 all expected samples delivered", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule